// File: doc/BRIEF.md
# Fractional-Capable 8x8 Multiply Unit

This unit is the multiplier of a small 8-bit processor core. The decoder passes it an operation select, the two operand values and their register indices. It also passes the current status byte and a start strobe. The unit checks that the register indices are allowed for the chosen variant. It then forms the 16-bit product, which the core writes to its fixed result pair: low byte to register 0, high byte to register 1. It also returns the status byte with only the zero and carry flags changed.

There are six variants. The plain forms treat both operands as unsigned, both as signed, or the first (destination) operand as signed and the second (source) operand as unsigned. Each plain form has a fractional twin, which doubles the product by shifting it left one place. All six variants share one datapath. Each operand is widened to nine bits with zero or sign extension, chosen by the variant, and one 9x9 signed multiply follows. The result appears two clock cycles after the start strobe, together with a one-cycle completion pulse. A request with a disallowed register index or an unused operation code produces a one-cycle illegal-operand pulse in place of the result.

Top module: `mul8_frac`

## Requirements
- R1: Operation code 0 multiplies the two operands as unsigned values, and any register index from 0 to 31 is allowed for either operand.
- R2: Operation code 1 multiplies the two operands as signed two's-complement values, and both register indices must lie in 16..31.
- R3: Operation code 2 treats the first operand as signed and the second as unsigned, and both register indices must lie in 16..23.
- R4: Operation codes 3, 4 and 5 are the fractional forms of codes 0, 1 and 2. The result is the 16-bit product shifted left by one bit, with bit 0 cleared, and both register indices must lie in 16..23.
- R5: The carry flag, bit 0 of the status output, equals bit 15 of the product before any fractional shift.
- R6: The zero flag, bit 1 of the status output, is set exactly when the 16-bit result is zero. Bits 7..2 of the status output equal those of the status input sampled with the start strobe.
- R7: A start strobe sampled at clock edge k drives the product and status outputs from edge k+1 and raises the completion pulse for exactly that one cycle. Starts on consecutive cycles produce results on consecutive cycles.
- R8: A disallowed register index or an operation code of 6 or 7 raises the illegal pulse, in the cycle a result would have appeared, instead of the completion pulse. The product and status outputs keep their previous values.
- R9: While reset is active, and until the first result, the product, status, completion and illegal outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, one per operation |
| op_i | input | 3 | Variant select, codes 0..5 |
| opd_a_i | input | 8 | Destination operand value |
| opd_b_i | input | 8 | Source operand value |
| reg_a_i | input | 5 | Register index of the destination operand |
| reg_b_i | input | 5 | Register index of the source operand |
| status_i | input | 8 | Status byte before the operation |
| prod_o | output | 16 | Result; bits 7..0 go to register 0, bits 15..8 to register 1 |
| status_o | output | 8 | Status byte with zero and carry updated |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| illegal_o | output | 1 | One-cycle pulse marking a rejected request |

## Verification
The properties assume that the status input is held steady by the core while a request is in flight. They also assume that every start strobe arrives with its operand values, indices and variant select already settled. The bench drives each request on the falling edge. It keeps all request inputs stable through the sampling rising edge and changes nothing on the input side while a result is pending. The single exception is the back-to-back case, where each new request is applied on its own falling edge.

// File: rtl/mul8_pkg.sv
package mul8_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned RW     = 5;
  localparam int unsigned SW     = 8;
  localparam int unsigned PW     = 2 * DW;
  localparam int unsigned C_BIT  = 0;
  localparam int unsigned Z_BIT  = 1;
  localparam int unsigned HI_LO  = 16;
  localparam int unsigned MID_HI = 23;

  localparam logic [2:0] OP_UU  = 3'd0;
  localparam logic [2:0] OP_SS  = 3'd1;
  localparam logic [2:0] OP_SU  = 3'd2;
  localparam logic [2:0] OP_FUU = 3'd3;
  localparam logic [2:0] OP_FSS = 3'd4;
  localparam logic [2:0] OP_FSU = 3'd5;

  typedef enum logic [1:0] {RNG_ANY, RNG_UPPER, RNG_MID, RNG_NONE} rng_e;

  function automatic rng_e op_range(input logic [2:0] op);
    case (op)
      OP_UU:                         return RNG_ANY;
      OP_SS:                         return RNG_UPPER;
      OP_SU, OP_FUU, OP_FSS, OP_FSU: return RNG_MID;
      default:                       return RNG_NONE;
    endcase
  endfunction

  // index 0: destination operand, index 1: source operand
  function automatic logic opd_signed(input logic [2:0] op, input int unsigned idx);
    case (op)
      OP_SS, OP_FSS: return 1'b1;
      OP_SU, OP_FSU: return (idx == 0);
      default:       return 1'b0;
    endcase
  endfunction

  function automatic logic op_frac(input logic [2:0] op);
    return (op == OP_FUU) || (op == OP_FSS) || (op == OP_FSU);
  endfunction
endpackage

// File: rtl/mul8_legal.sv
module mul8_legal
  import mul8_pkg::*;
#(
  parameter int unsigned REG_W = RW
) (
  input  logic [2:0]       op_i,
  input  logic [REG_W-1:0] reg_a_i,
  input  logic [REG_W-1:0] reg_b_i,
  output logic             legal_o
);
  localparam int unsigned NOPD = 2;

  rng_e            rng;
  logic [NOPD-1:0] ok;

  assign rng = op_range(op_i);

  for (genvar g = 0; g < NOPD; g++) begin : g_opd
    logic [REG_W-1:0] idx;
    assign idx = (g == 0) ? reg_a_i : reg_b_i;
    always_comb begin
      case (rng)
        RNG_ANY:   ok[g] = 1'b1;
        RNG_UPPER: ok[g] = (32'(idx) >= HI_LO);
        RNG_MID:   ok[g] = (32'(idx) >= HI_LO) && (32'(idx) <= MID_HI);
        default:   ok[g] = 1'b0;
      endcase
    end
  end

  assign legal_o = &ok;
endmodule

// File: rtl/mul8_prep.sv
module mul8_prep
  import mul8_pkg::*;
#(
  parameter int unsigned WIDTH = DW
) (
  input  logic [2:0]             op_i,
  input  logic [WIDTH-1:0]       a_i,
  input  logic [WIDTH-1:0]       b_i,
  output logic signed [WIDTH:0]  ax_o,
  output logic signed [WIDTH:0]  bx_o
);
  localparam int unsigned NOPD = 2;

  logic [NOPD-1:0][WIDTH:0] ext;

  for (genvar g = 0; g < NOPD; g++) begin : g_ext
    logic [WIDTH-1:0] v;
    logic             sgn;
    assign v      = (g == 0) ? a_i : b_i;
    assign sgn    = opd_signed(op_i, g);
    assign ext[g] = {sgn & v[WIDTH-1], v};
  end

  assign ax_o = signed'(ext[0]);
  assign bx_o = signed'(ext[1]);
endmodule

// File: rtl/mul8_core.sv
module mul8_core
  import mul8_pkg::*;
#(
  parameter int unsigned WIDTH = DW
) (
  input  logic signed [WIDTH:0]   ax_i,
  input  logic signed [WIDTH:0]   bx_i,
  input  logic                    frac_i,
  output logic [2*WIDTH-1:0]      res_o,
  output logic                    c_o,
  output logic                    z_o
);
  localparam int unsigned FW = 2 * WIDTH + 2;
  localparam int unsigned OW = 2 * WIDTH;

  logic signed [FW-1:0] full;
  logic [OW-1:0]        raw;

  assign full  = FW'(ax_i) * FW'(bx_i);
  assign raw   = full[OW-1:0];
  assign res_o = frac_i ? {raw[OW-2:0], 1'b0} : raw;
  assign c_o   = raw[OW-1];
  assign z_o   = (res_o == '0);
endmodule

// File: rtl/mul8_frac.sv
module mul8_frac
  import mul8_pkg::*;
#(
  parameter int unsigned WIDTH = DW,
  parameter int unsigned REG_W = RW,
  parameter int unsigned ST_W  = SW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [2:0]           op_i,
  input  logic [WIDTH-1:0]     opd_a_i,
  input  logic [WIDTH-1:0]     opd_b_i,
  input  logic [REG_W-1:0]     reg_a_i,
  input  logic [REG_W-1:0]     reg_b_i,
  input  logic [ST_W-1:0]      status_i,
  output logic [2*WIDTH-1:0]   prod_o,
  output logic [ST_W-1:0]      status_o,
  output logic                 done_o,
  output logic                 illegal_o
);
  localparam int unsigned OW = 2 * WIDTH;

  logic                   legal;
  logic signed [WIDTH:0]  ax, bx;
  logic                   s1_vld, s1_ill, s1_frac;
  logic signed [WIDTH:0]  s1_ax, s1_bx;
  logic [ST_W-1:0]        s1_st;
  logic [OW-1:0]          res;
  logic                   c_flag, z_flag;
  logic [ST_W-1:0]        st_next;

  mul8_legal #(.REG_W(REG_W)) u_legal (
    .op_i    (op_i),
    .reg_a_i (reg_a_i),
    .reg_b_i (reg_b_i),
    .legal_o (legal)
  );

  mul8_prep #(.WIDTH(WIDTH)) u_prep (
    .op_i (op_i),
    .a_i  (opd_a_i),
    .b_i  (opd_b_i),
    .ax_o (ax),
    .bx_o (bx)
  );

  // stage 1: capture widened operands and status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_ill  <= 1'b0;
      s1_frac <= 1'b0;
      s1_ax   <= '0;
      s1_bx   <= '0;
      s1_st   <= '0;
    end else begin
      s1_vld <= start_i & legal;
      s1_ill <= start_i & ~legal;
      if (start_i & legal) begin
        s1_frac <= op_frac(op_i);
        s1_ax   <= ax;
        s1_bx   <= bx;
        s1_st   <= status_i;
      end
    end
  end

  mul8_core #(.WIDTH(WIDTH)) u_core (
    .ax_i   (s1_ax),
    .bx_i   (s1_bx),
    .frac_i (s1_frac),
    .res_o  (res),
    .c_o    (c_flag),
    .z_o    (z_flag)
  );

  always_comb begin
    st_next        = s1_st;
    st_next[C_BIT] = c_flag;
    st_next[Z_BIT] = z_flag;
  end

  // stage 2: result registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_o    <= '0;
      status_o  <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= s1_vld;
      illegal_o <= s1_ill;
      if (s1_vld) begin
        prod_o   <= res;
        status_o <= st_next;
      end
    end
  end
endmodule

// File: rtl/mul8_frac_chk.sv
module mul8_frac_chk
  import mul8_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [SW-1:0] status_i,
  input logic [PW-1:0] prod_o,
  input logic [SW-1:0] status_o,
  input logic          done_o,
  input logic          illegal_o
);
  // R7
  done_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 2));

  // R8
  ill_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(start_i, 2));

  // R8
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(prod_o) && $stable(status_o)));

  // R6
  keep_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o[SW-1:2] == $past(status_i[SW-1:2], 2)));

  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o[Z_BIT] == (prod_o == '0)));
endmodule

bind mul8_frac mul8_frac_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .status_i  (status_i),
  .prod_o    (prod_o),
  .status_o  (status_o),
  .done_o    (done_o),
  .illegal_o (illegal_o)
);

// File: tb/mul8_frac_test.sv
`timescale 1ns/1ps
module mul8_frac_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [7:0]  a = '0, b = '0;
  logic [4:0]  ra = '0, rb = '0;
  logic [7:0]  st = '0;
  logic [15:0] prod;
  logic [7:0]  st_o;
  logic        done, ill;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  mul8_frac uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .opd_a_i(a), .opd_b_i(b), .reg_a_i(ra), .reg_b_i(rb),
    .status_i(st), .prod_o(prod), .status_o(st_o),
    .done_o(done), .illegal_o(ill)
  );

  // {op, a, b, ra, rb, status_in, expected result, expected carry, illegal}
  localparam int NV = 15;
  localparam logic [54:0] VEC [NV] = '{
    {3'd0, 8'hFF, 8'hFF, 5'd0,  5'd31, 8'hA4, 16'hFE01, 1'b1, 1'b0},
    {3'd0, 8'h10, 8'h10, 5'd5,  5'd6,  8'h03, 16'h0100, 1'b0, 1'b0},
    {3'd1, 8'hFF, 8'hFF, 5'd16, 5'd31, 8'h5A, 16'h0001, 1'b0, 1'b0},
    {3'd1, 8'h80, 8'h7F, 5'd20, 5'd30, 8'h00, 16'hC080, 1'b1, 1'b0},
    {3'd2, 8'hFF, 8'hFF, 5'd16, 5'd23, 8'hFF, 16'hFF01, 1'b1, 1'b0},
    {3'd3, 8'h80, 8'h80, 5'd17, 5'd18, 8'h81, 16'h8000, 1'b0, 1'b0},
    {3'd4, 8'h80, 8'h80, 5'd23, 5'd16, 8'h42, 16'h8000, 1'b0, 1'b0},
    {3'd5, 8'hC0, 8'h80, 5'd19, 5'd20, 8'h3C, 16'hC000, 1'b1, 1'b0},
    {3'd5, 8'h01, 8'hFF, 5'd22, 5'd21, 8'h10, 16'h01FE, 1'b0, 1'b0},
    {3'd0, 8'h00, 8'h55, 5'd31, 5'd0,  8'h01, 16'h0000, 1'b0, 1'b0},
    {3'd3, 8'h80, 8'h00, 5'd16, 5'd16, 8'hFE, 16'h0000, 1'b0, 1'b0},
    {3'd1, 8'h12, 8'h34, 5'd15, 5'd16, 8'h77, 16'h0000, 1'b0, 1'b1},
    {3'd2, 8'h01, 8'h01, 5'd16, 5'd24, 8'h77, 16'h0000, 1'b0, 1'b1},
    {3'd3, 8'h01, 8'h01, 5'd8,  5'd16, 8'h77, 16'h0000, 1'b0, 1'b1},
    {3'd6, 8'h01, 8'h01, 5'd16, 5'd16, 8'h77, 16'h0000, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic apply(input logic [54:0] v);
    op = v[54:52]; a = v[51:44]; b = v[43:36];
    ra = v[35:31]; rb = v[30:26]; st = v[25:18];
    start = 1'b1;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [15:0] last_p;
    logic [7:0]  last_s;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9", "prod", 32'(prod), 0);
    chk("R9", "status", 32'(st_o), 0);
    chk("R9", "done", 32'(done), 0);
    chk("R9", "illegal", 32'(ill), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "prod after release", 32'(prod), 0);
    last_p = '0;
    last_s = '0;

    // R1 R2 R3 R4 R5 R6 R8 table walk
    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      logic [15:0] ep;
      logic [7:0]  es;
      v = VEC[i];
      apply(v);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      if (v[0]) begin
        ep = last_p; es = last_s;
        chk("R8", $sformatf("illegal pulse v%0d", i), 32'(ill), 1);
        chk("R8", $sformatf("no done v%0d", i), 32'(done), 0);
      end else begin
        ep = v[17:2];
        es = {v[25:20], (v[17:2] == 16'h0), v[1]};
        chk("R7", $sformatf("done v%0d", i), 32'(done), 1);
        chk("R8", $sformatf("no illegal v%0d", i), 32'(ill), 0);
      end
      chk("R1-4 result", $sformatf("prod v%0d", i), 32'(prod), 32'(ep));
      chk("R5 R6", $sformatf("status v%0d", i), 32'(st_o), 32'(es));
      last_p = prod;
      last_s = st_o;
      @(negedge clk);
      chk("R7", $sformatf("single pulse v%0d", i), 32'({done, ill}), 0);
    end

    // R7 back-to-back starts
    apply(VEC[0]);
    @(negedge clk);
    apply(VEC[3]);
    @(negedge clk);
    start = 1'b0;
    chk("R7", "b2b first done", 32'(done), 1);
    chk("R7", "b2b first prod", 32'(prod), 32'h0000FE01);
    @(negedge clk);
    chk("R7", "b2b second done", 32'(done), 1);
    chk("R7", "b2b second prod", 32'(prod), 32'h0000C080);
    chk("R5", "b2b second carry", 32'(st_o[0]), 1);
    @(negedge clk);
    chk("R7", "b2b done falls", 32'(done), 0);

    // R9 reset while in flight
    apply(VEC[4]);
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "flush done", 32'(done), 0);
    chk("R9", "flush prod", 32'(prod), 0);
    chk("R9", "flush status", 32'(st_o), 0);

    finish_run();
  end
endmodule